// File: doc/BRIEF.md
# Double-Buffered Converter Input Register Front End

This block is the digital front end of a 16-bit digital-to-analog converter that sits on an 8-bit processor bus. A word can be assembled in a pair of 8-bit holding registers in two ways. In byte mode the processor writes the upper and lower halves with two separate bus writes. In serial mode a bit stream is shifted in, most significant bit first, on a single data pin. A separate transfer write then copies the assembled word into the converter register, which drives the converter core. Because of this, a new word can be prepared while the old one is still on the output.

The bus signals (write strobe, chip select, clear and three register enables) are all active low. The write strobe is asynchronous to the system clock. It passes through a two-stage synchronizer and a two-state strobe machine. The machine's states are `STB_RELEASED` and `STB_ASSERTED`. The transition "press" goes from `STB_RELEASED` to `STB_ASSERTED` when the synchronized strobe is low, and it emits one load pulse. The transition "release" goes from `STB_ASSERTED` back to `STB_RELEASED` when the synchronized strobe is high again. Each state stays put otherwise. The other inputs are sampled at the clock edge where the load pulse is active, so they must be held steady for the whole strobe.

A coding input selects the input format. At 0 the input is two's complement and passes through unchanged. At 1 the input is straight binary, and bit 15 is inverted on its way into the converter register. Clear is synchronous and has priority over every load. It zeroes both holding registers and puts the word that gives a zero output for the selected coding into the converter register.

Top module: `dac_front_end`

## Requirements
- R1: While reset is active and after it is released, `code_out` is 0x0000 and `code_upd` is 0. Both holding registers start at zero, so a transfer with coding 0 right after reset leaves `code_out` at 0x0000.
- R2: Consider a strobe with `cs_n`=0, `hb_en_n`=0 and `lb_en_n`=1. It loads `din[7:0]` into holding-word bits 15:8, with `din[7]` going to bit 15. It leaves bits 7:0 unchanged.
- R3: Consider a strobe with `cs_n`=0, `hb_en_n`=1 and `lb_en_n`=0. It loads `din[7:0]` into holding-word bits 7:0 and leaves bits 15:8 unchanged.
- R4: Consider a strobe with `cs_n`=0, `hb_en_n`=0 and `lb_en_n`=0. It shifts the 16-bit holding word left by one place, and `din[0]` enters at bit 0. Sixteen such strobes leave the first bit sent at bit 15. Every further strobe drops the oldest bit.
- R5: The converter register takes the holding word only on a strobe with `cs_n`=0 and `xfer_en_n`=0. Holding-register writes made with `xfer_en_n`=1 leave `code_out` unchanged.
- R6: A strobe with `cs_n`=1 changes neither the holding registers nor the converter register.
- R7: Each high-to-low transition of `wr_n` causes exactly one load, however long `wr_n` stays low.
- R8: On transfer, `code_out` equals the holding word when `ubin_mode`=0. It equals the holding word with bit 15 inverted when `ubin_mode`=1.
- R9: While `clr_n`=0, every strobe is ignored. Both holding registers become zero, and `code_out` becomes 0x0000 when `ubin_mode`=0 or 0x8000 when `ubin_mode`=1.
- R10: `code_upd` is high for exactly the cycles in which `code_out` differs from its value one cycle earlier. A transfer that rewrites the same value gives no pulse.
- R11: `wr_n` is sampled by the clock. After the first rising edge that samples it low, `code_out` stays the same for one further edge and takes its new value at the third edge.
- R12: When a transfer and a holding-register write happen in the same strobe, the converter register takes the holding word as it was before that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Bus data; bit 0 also serves as the serial data pin |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| cs_n | input | 1 | Active-low chip select, qualifies every load |
| clr_n | input | 1 | Active-low synchronous clear |
| hb_en_n | input | 1 | Active-low enable of the upper holding byte |
| lb_en_n | input | 1 | Active-low enable of the lower holding byte |
| xfer_en_n | input | 1 | Active-low enable of the converter register |
| ubin_mode | input | 1 | 0: two's complement input, 1: straight binary input |
| code_out | output | 16 | Converter register contents |
| code_upd | output | 1 | High for one cycle whenever code_out changes |

## Verification
The byte lanes are swept over all 256 values in both codings. The upper byte gets each value and the lower byte gets its complement, and a separate transfer follows each pair. This tells a swapped lane, a swapped bit order or a missing bit 15 inversion apart from a correct mapping. The serial streams cover alternating, single-one, top-bit-only and all-ones words, plus a 20-bit stream that overflows the register. These show the shift direction and the loss of the oldest bits.

Other patterns target single behaviours:
- Writes with the chip select high, or with transfer disabled, test the gating.
- A long-held strobe shows that one strobe gives one load.
- A transfer combined with a byte write shows which holding value is taken.
- A repeated transfer shows that an unchanged value gives no update pulse.
- A clear with a strobe inside it, followed by a coding change and a transfer, shows both the clear word and the zeroed holding registers.
- Cycle-exact sampling around one strobe pins the synchronizer latency.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    // Holding-register operation selected by the two byte enables
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_HIGH   = 2'd1,
        OP_LOW    = 2'd2,
        OP_SERIAL = 2'd3
    } hold_op_e;

    // Write strobe tracker states
    typedef enum logic {
        STB_RELEASED = 1'b0,
        STB_ASSERTED = 1'b1
    } stb_state_e;

    // Both enables low selects shifting; otherwise one lane or none
    function automatic hold_op_e decode_op(input logic hb_n, input logic lb_n);
        hold_op_e op;
        unique case ({hb_n, lb_n})
            2'b00:   op = OP_SERIAL;
            2'b01:   op = OP_HIGH;
            2'b10:   op = OP_LOW;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/dac_fe_strobe.sv
module dac_fe_strobe #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic load_pulse
);
    import dac_fe_pkg::*;

    // Synchronizer chain, idle level is high (strobe released)
    logic [SYNC_STAGES-1:0] sync_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= wr_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    logic wr_sync_n;
    assign wr_sync_n = sync_q[SYNC_STAGES-1];

    stb_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STB_RELEASED;
        else        state_q <= state_d;
    end

    // Transitions and output
    always_comb begin
        state_d    = state_q;
        load_pulse = 1'b0;
        unique case (state_q)
            STB_RELEASED: begin
                if (!wr_sync_n) begin
                    state_d    = STB_ASSERTED;  // press
                    load_pulse = 1'b1;
                end
            end
            STB_ASSERTED: begin
                if (wr_sync_n) begin
                    state_d = STB_RELEASED;     // release
                end
            end
            default: state_d = STB_RELEASED;
        endcase
    end

endmodule

// File: rtl/dac_fe_hold.sv
module dac_fe_hold #(
    parameter int BYTE_W  = 8,
    parameter int SER_BIT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  load,
    input  dac_fe_pkg::hold_op_e  op,
    input  logic [BYTE_W-1:0]     din,
    output logic [2*BYTE_W-1:0]   word
);
    import dac_fe_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;
    localparam int LANES  = 2;

    logic [WORD_W-1:0] shifted;
    assign shifted = {word[WORD_W-2:0], din[SER_BIT]};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Lane 1 is the upper byte, lane 0 the lower byte
            localparam hold_op_e LANE_OP = (g == LANES - 1) ? OP_HIGH : OP_LOW;
            logic [BYTE_W-1:0] lane_q, lane_d;

            always_comb begin
                lane_d = lane_q;
                if (!clr_n) begin
                    lane_d = '0;
                end else if (load) begin
                    if (op == OP_SERIAL)   lane_d = shifted[g*BYTE_W +: BYTE_W];
                    else if (op == LANE_OP) lane_d = din;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lane_q <= '0;
                else        lane_q <= lane_d;
            end

            assign word[g*BYTE_W +: BYTE_W] = lane_q;
        end
    endgenerate

endmodule

// File: rtl/dac_fe_conv.sv
module dac_fe_conv #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              load,
    input  logic              xfer_en_n,
    input  logic              ubin_mode,
    input  logic [WORD_W-1:0] hold_word,
    output logic [WORD_W-1:0] code,
    output logic              upd
);
    localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] flip, code_d;

    // Straight binary input gets its top bit inverted
    assign flip = ubin_mode ? TOP_BIT : '0;

    always_comb begin
        code_d = code;
        if (!clr_n) begin
            code_d = flip;              // zero output in either coding
        end else if (load && !xfer_en_n) begin
            code_d = hold_word ^ flip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            upd  <= 1'b0;
        end else begin
            code <= code_d;
            upd  <= (code_d != code);
        end
    end

endmodule

// File: rtl/dac_front_end.sv
module dac_front_end #(
    parameter int BYTE_W      = 8,
    parameter int SER_BIT     = 0,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              clr_n,
    input  logic              hb_en_n,
    input  logic              lb_en_n,
    input  logic              xfer_en_n,
    input  logic              ubin_mode,
    output logic [WORD_W-1:0] code_out,
    output logic              code_upd
);
    import dac_fe_pkg::*;

    logic              strobe;
    logic              load;
    hold_op_e          op;
    logic [WORD_W-1:0] hold_word;

    assign load = strobe && !cs_n;
    assign op   = decode_op(hb_en_n, lb_en_n);

    dac_fe_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .load_pulse (strobe)
    );

    dac_fe_hold #(.BYTE_W(BYTE_W), .SER_BIT(SER_BIT)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .load  (load),
        .op    (op),
        .din   (din),
        .word  (hold_word)
    );

    dac_fe_conv #(.WORD_W(WORD_W)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .load      (load),
        .xfer_en_n (xfer_en_n),
        .ubin_mode (ubin_mode),
        .hold_word (hold_word),
        .code      (code_out),
        .upd       (code_upd)
    );

endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n,
    input logic              cs_n,
    input logic              clr_n,
    input logic              xfer_en_n,
    input logic              ubin_mode,
    input logic [WORD_W-1:0] code_out,
    input logic              code_upd
);
    localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    // R9
    clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> code_out == ($past(ubin_mode) ? TOP_BIT : '0));

    // R6
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && clr_n) |=> $stable(code_out));

    // R5
    xfer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en_n && clr_n) |=> $stable(code_out));

    // R10
    upd_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out != $past(code_out)) |-> code_upd);

    // R10
    upd_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |-> (code_out != $past(code_out)));

    // R11
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_n, 2) && clr_n) |=> $stable(code_out));

endmodule

bind dac_front_end dac_fe_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .cs_n      (cs_n),
    .clr_n     (clr_n),
    .xfer_en_n (xfer_en_n),
    .ubin_mode (ubin_mode),
    .code_out  (code_out),
    .code_upd  (code_upd)
);

// File: tb/tb_dac_front_end.sv
module tb_dac_front_end;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        wr_n = 1'b1, cs_n = 1'b1, clr_n = 1'b1;
    logic        hb_en_n = 1'b1, lb_en_n = 1'b1, xfer_en_n = 1'b1;
    logic        ubin_mode = 1'b0;
    logic [15:0] code_out;
    logic        code_upd;

    int          n_chk = 0, n_bad = 0, upd_cnt = 0;
    bit          done = 1'b0;
    logic [15:0] m_hold = 16'h0, m_conv = 16'h0;

    dac_front_end dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_n(wr_n), .cs_n(cs_n),
        .clr_n(clr_n), .hb_en_n(hb_en_n), .lb_en_n(lb_en_n),
        .xfer_en_n(xfer_en_n), .ubin_mode(ubin_mode),
        .code_out(code_out), .code_upd(code_upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (code_upd) upd_cnt++;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] d, input logic hb, input logic lb,
                         input logic xf, input logic c, input int lowc, input string tag);
        logic [15:0] nh, nc;
        nh = m_hold; nc = m_conv;
        if (!c) begin
            if (!hb && !lb)  nh = {m_hold[14:0], d[0]};
            else if (!hb)    nh = {d, m_hold[7:0]};
            else if (!lb)    nh = {m_hold[15:8], d};
            if (!xf)         nc = m_hold ^ (ubin_mode ? 16'h8000 : 16'h0000); // R12 old hold
        end
        @(negedge clk);
        din = d; hb_en_n = hb; lb_en_n = lb; xfer_en_n = xf; cs_n = c;
        upd_cnt = 0; wr_n = 1'b0;
        repeat (lowc) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(tag, code_out, nc);
        chk("R10", 16'(upd_cnt), (nc != m_conv) ? 16'd1 : 16'd0);
        m_hold = nh; m_conv = nc;
        hb_en_n = 1'b1; lb_en_n = 1'b1; xfer_en_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic xfer(input string tag);
        drive(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3, tag);
    endtask

    task automatic send_serial(input logic [31:0] bits, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--)
            drive({7'h0, bits[i]}, 1'b0, 1'b0, 1'b1, 1'b0, 3, tag);
    endtask

    task automatic do_clear(input string tag);
        logic [15:0] nc;
        nc = ubin_mode ? 16'h8000 : 16'h0000;
        @(negedge clk); upd_cnt = 0; clr_n = 1'b0;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tag, code_out, nc);
        chk("R10", 16'(upd_cnt), (nc != m_conv) ? 16'd1 : 16'd0);
        m_hold = 16'h0; m_conv = nc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", code_out, 16'h0000);
        chk("R1", {15'h0, code_upd}, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", code_out, 16'h0000);
        xfer("R1");

        // R2 R3 R8 lane sweeps in both codings, R5 no change before transfer
        for (int m = 0; m < 2; m++) begin
            ubin_mode = m[0];
            for (int v = 0; v < 256; v++) begin
                drive(8'(v), 1'b0, 1'b1, 1'b1, 1'b0, 2, "R2");
                drive(~8'(v), 1'b1, 1'b0, 1'b1, 1'b0, 2, "R3");
                xfer("R8");
            end
        end
        ubin_mode = 1'b0;

        // R4 serial words, MSB first
        send_serial(32'h0000A5C3, 16, "R4"); xfer("R4");
        send_serial(32'h00000001, 16, "R4"); xfer("R4");
        send_serial(32'h00008000, 16, "R4"); xfer("R4");
        send_serial(32'h0000FFFF, 16, "R4"); xfer("R4");
        send_serial(32'h0009C35A, 20, "R4"); xfer("R4");   // oldest 4 bits lost
        chk("R4", code_out, 16'hC35A);
        xfer("R10");                                       // same value, no pulse

        // R6 chip select high blocks loads and transfer
        drive(8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 2, "R6");
        xfer("R6");

        // R7 long strobe in serial mode shifts once
        drive(8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 25, "R7");
        xfer("R7");

        // R5 writes without transfer keep output
        drive(8'h12, 1'b0, 1'b1, 1'b1, 1'b0, 2, "R5");
        chk("R5", code_out, m_conv);

        // R11 R12 cycle-exact: byte write plus transfer in one strobe
        @(negedge clk);
        din = 8'h3C; hb_en_n = 1'b1; lb_en_n = 1'b0; xfer_en_n = 1'b0; cs_n = 1'b0;
        wr_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R11", code_out, m_conv);
        @(posedge clk); #1;
        chk("R12", code_out, m_hold);
        @(negedge clk); wr_n = 1'b1;
        repeat (6) @(negedge clk);
        m_conv = m_hold; m_hold = {m_hold[15:8], 8'h3C};
        hb_en_n = 1'b1; lb_en_n = 1'b1; xfer_en_n = 1'b1; cs_n = 1'b1;
        xfer("R12");

        // R9 clear in both codings, strobe inside clear ignored
        drive(8'hAB, 1'b0, 1'b1, 1'b1, 1'b0, 2, "R9");
        ubin_mode = 1'b1;
        do_clear("R9");
        ubin_mode = 1'b0;
        do_clear("R9");
        drive(8'h5D, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R9");
        ubin_mode = 1'b1;
        @(negedge clk); clr_n = 1'b0;
        din = 8'hFF; hb_en_n = 1'b0; lb_en_n = 1'b1; xfer_en_n = 1'b0; cs_n = 1'b0;
        wr_n = 1'b0; repeat (3) @(negedge clk);
        wr_n = 1'b1; repeat (6) @(negedge clk);
        hb_en_n = 1'b1; xfer_en_n = 1'b1; cs_n = 1'b1;
        clr_n = 1'b1; repeat (2) @(negedge clk);
        chk("R9", code_out, 16'h8000);
        m_hold = 16'h0; m_conv = 16'h8000;
        ubin_mode = 1'b0;
        xfer("R9");                                        // holding zero gives 0x0000

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule